// File: doc/BRIEF.md
# Ingress Control Frame Filter

This block sits at the very front of a receive path, ahead of any security processing. When the header of an incoming Ethernet frame is complete, the block compares its destination address, source address and ethertype against a small table of rules. Each rule holds a stored value and a mask with one bit per nibble, and it chooses which header fields to compare. The first valid rule that matches sets a registered decision. That decision says whether the frame was claimed and whether it skips all later classification stages.

Software or a management agent programs the rules through a simple port. It gives a row address, a table select, a data word, and one-cycle write and read strobes. A read returns the row one cycle after its strobe.

Top module: `ctlf_filter`

## Requirements
- R1: After reset, `decValid` and `cfgRdValid` are low and every row reads back as all zeros, which is type 0 (unused).
- R2: A write strobe with `cfgSel` equal to 0 and `cfgAddr` below 24 stores `cfgWrData` in that row. The row word is packed as follows: bits [83:36] hold the address value, [35:20] the ethertype value, [19:4] the nibble mask, [3:1] the match type and [0] the action. A read strobe raises `cfgRdValid` for exactly the next cycle, with the row on `cfgRdData` in that cycle.
- R3: A write with `cfgSel` not 0, or with `cfgAddr` of 24 or more, changes no row. A read under either condition still raises `cfgRdValid`, but returns all zeros.
- R4: `decValid` is high exactly in the cycle after each `hdrDone` strobe. The header inputs are sampled at the strobe.
- R5: A row with match type 0 never matches, whatever its stored value is.
- R6: The compare word is {48-bit field, 16-bit ethertype}. Mask bit i covers word bits [4i+3:4i], and a mask bit of 0 makes that nibble match always. Type 1 compares the destination address under mask bits [15:4].
- R7: Type 2 compares the source address. Type 3 compares the upper 24 bits of the destination address followed by the lower 24 bits of the source address. Both use mask bits [15:4].
- R8: Type 4 compares only the ethertype, under mask bits [3:0]. Type 5 compares destination address plus ethertype under all 16 mask bits. Type 6 compares source address plus ethertype under all 16 mask bits.
- R9: Type 7 matches when the destination address lies between the stored address and the stored address plus the stored ethertype value, both bounds inclusive, with no wrap. The mask is ignored for this type.
- R10: When several rows match, the lowest-indexed row wins, and its index appears on `decRow`.
- R11: When no row matches, `decMatch`, `decBypass` and `decRow` are all 0 in the decision cycle.
- R12: `decBypass` is high only when a row matched and that row's action bit is 0. Action 1 gives a match with `decBypass` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | 9 | Row address for configuration access |
| cfgSel | input | 4 | Table select; only value 0 addresses this table |
| cfgWr | input | 1 | One-cycle write strobe |
| cfgRd | input | 1 | One-cycle read strobe |
| cfgWrData | input | 84 | Row data to write |
| cfgRdData | output | 84 | Row data returned by a read |
| cfgRdValid | output | 1 | High in the cycle after a read strobe |
| hdrDone | input | 1 | Header-complete strobe |
| hdrDa | input | 48 | Destination address of the current frame |
| hdrSa | input | 48 | Source address of the current frame |
| hdrEtype | input | 16 | Ethertype of the current frame |
| decValid | output | 1 | Decision valid strobe |
| decMatch | output | 1 | Some valid row matched |
| decBypass | output | 1 | Frame skips all later stages |
| decRow | output | 5 | Index of the winning row |

## Verification
The checker watches every cycle for the following properties:
- the one-cycle timing of both the decision strobe and the read-return strobe;
- zero data returned by reads that fall outside the table;
- bypass appearing only together with a match;
- a clean decision when nothing matches;
- the winning row index staying inside the table.

Only the bench scenarios can show that the right row wins. They cover:
- each of the eight compare modes and nibble masking;
- the inclusive range bounds;
- lowest-index priority between overlapping rows.

The bench checks these against an arithmetic model of the rule table over directed frames and a long pseudo-random sweep. In that sweep, rows are reprogrammed while frames are being classified.

// File: rtl/ctlf_pkg.sv
package ctlf_pkg;
  localparam int ADDR_BITS = 48;
  localparam int ET_BITS   = 16;
  localparam int NIBS      = 16;
  localparam int WORD_BITS = ADDR_BITS + ET_BITS;

  typedef enum logic [2:0] {
    MT_OFF      = 3'd0,
    MT_DA       = 3'd1,
    MT_SA       = 3'd2,
    MT_HALF     = 3'd3,
    MT_ET       = 3'd4,
    MT_DA_ET    = 3'd5,
    MT_SA_ET    = 3'd6,
    MT_DA_RANGE = 3'd7
  } matchType_t;

  typedef struct packed {
    logic [ADDR_BITS-1:0] addrVal;
    logic [ET_BITS-1:0]   etypeVal;
    logic [NIBS-1:0]      nibMask;
    matchType_t           mType;
    logic                 action;
  } ctlfRow_t;

  localparam int ROW_W = $bits(ctlfRow_t);

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic rdOk;
    logic decide;
  } ctlStrobe_t;
endpackage

// File: rtl/ctlf_ctrl.sv
module ctlf_ctrl
  import ctlf_pkg::*;
#(
  parameter int ROWS      = 24,
  parameter int ADDR_W    = 9,
  parameter int SEL_W     = 4,
  parameter int TABLE_SEL = 0,
  localparam int IDX_W    = $clog2(ROWS)
) (
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic              cfgWr,
  input  logic              cfgRd,
  input  logic              hdrDone,
  output ctlStrobe_t        stb,
  output logic [IDX_W-1:0]  rowIdx
);
  logic addrOk;

  // A row access is legal only on our select code and inside the table
  assign addrOk = (cfgSel == SEL_W'(TABLE_SEL)) && (cfgAddr < ADDR_W'(ROWS));

  always_comb begin
    stb.wrEn   = cfgWr && addrOk;
    stb.rdEn   = cfgRd;
    stb.rdOk   = cfgRd && addrOk;
    stb.decide = hdrDone;
  end

  assign rowIdx = cfgAddr[IDX_W-1:0];
endmodule

// File: rtl/ctlf_entry_cmp.sv
module ctlf_entry_cmp
  import ctlf_pkg::*;
(
  input  ctlfRow_t             row,
  input  logic [ADDR_BITS-1:0] da,
  input  logic [ADDR_BITS-1:0] sa,
  input  logic [ET_BITS-1:0]   et,
  output logic                 hit
);
  logic [ADDR_BITS-1:0] selField;
  logic [NIBS-1:0]      typeMask;
  logic [NIBS-1:0]      effMask;
  logic [WORD_BITS-1:0] frameWord;
  logic [WORD_BITS-1:0] storeWord;
  logic [NIBS-1:0]      nibOk;
  logic [ADDR_BITS:0]   upperBound;
  logic                 inRange;

  localparam logic [NIBS-1:0] ADDR_NIBS = {{(NIBS-ET_BITS/4){1'b1}}, {(ET_BITS/4){1'b0}}};
  localparam logic [NIBS-1:0] ET_NIBS   = ~ADDR_NIBS;

  // Pick the 48-bit field and the nibbles that this match type cares about
  always_comb begin
    selField = '0;
    typeMask = '0;
    case (row.mType)
      MT_DA:    begin selField = da; typeMask = ADDR_NIBS; end
      MT_SA:    begin selField = sa; typeMask = ADDR_NIBS; end
      MT_HALF:  begin
                  selField = {da[ADDR_BITS-1:ADDR_BITS/2], sa[ADDR_BITS/2-1:0]};
                  typeMask = ADDR_NIBS;
                end
      MT_ET:    begin selField = '0; typeMask = ET_NIBS; end
      MT_DA_ET: begin selField = da; typeMask = '1; end
      MT_SA_ET: begin selField = sa; typeMask = '1; end
      default:  begin selField = '0; typeMask = '0; end
    endcase
  end

  assign frameWord = {selField, et};
  assign storeWord = {row.addrVal, row.etypeVal};
  assign effMask   = row.nibMask & typeMask;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign nibOk[g] = !effMask[g] || (frameWord[4*g +: 4] == storeWord[4*g +: 4]);
  end

  // Range mode: inclusive window [addrVal, addrVal + etypeVal], no wrap
  assign upperBound = {1'b0, row.addrVal} + {{(ADDR_BITS+1-ET_BITS){1'b0}}, row.etypeVal};
  assign inRange    = (da >= row.addrVal) && ({1'b0, da} <= upperBound);

  always_comb begin
    case (row.mType)
      MT_OFF:      hit = 1'b0;
      MT_DA_RANGE: hit = inRange;
      default:     hit = &nibOk;
    endcase
  end
endmodule

// File: rtl/ctlf_datapath.sv
module ctlf_datapath
  import ctlf_pkg::*;
#(
  parameter int ROWS   = 24,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           stb,
  input  logic [IDX_W-1:0]     rowIdx,
  input  ctlfRow_t             wrRow,
  input  logic [ADDR_BITS-1:0] da,
  input  logic [ADDR_BITS-1:0] sa,
  input  logic [ET_BITS-1:0]   et,
  output ctlfRow_t             rdRow,
  output logic                 rdValid,
  output logic                 decValid,
  output logic                 decMatch,
  output logic                 decBypass,
  output logic [IDX_W-1:0]     decRow
);
  ctlfRow_t         tbl [ROWS];
  logic [ROWS-1:0]  hitVec;
  logic             anyHit;
  logic [IDX_W-1:0] winIdx;

  // Rule storage; reset leaves every row unused
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) tbl[i] <= '0;
    end else if (stb.wrEn) begin
      tbl[rowIdx] <= wrRow;
    end
  end

  // One comparator per row
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    ctlf_entry_cmp u_cmp (
      .row(tbl[r]),
      .da (da),
      .sa (sa),
      .et (et),
      .hit(hitVec[r])
    );
  end

  // Lowest index wins: scan downward so the last hit written is the smallest
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decMatch  <= 1'b0;
      decBypass <= 1'b0;
      decRow    <= '0;
    end else begin
      decValid <= stb.decide;
      if (stb.decide) begin
        decMatch  <= anyHit;
        decBypass <= anyHit && !tbl[winIdx].action;
        decRow    <= anyHit ? winIdx : '0;
      end
    end
  end

  // Read port: one cycle latency, zero data for illegal accesses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdRow   <= '0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn) rdRow <= stb.rdOk ? tbl[rowIdx] : '0;
    end
  end
endmodule

// File: rtl/ctlf_filter.sv
module ctlf_filter
  import ctlf_pkg::*;
#(
  parameter int ROWS      = 24,
  parameter int ADDR_W    = 9,
  parameter int SEL_W     = 4,
  parameter int TABLE_SEL = 0,
  localparam int IDX_W    = $clog2(ROWS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             cfgAddr,
  input  logic [SEL_W-1:0]              cfgSel,
  input  logic                          cfgWr,
  input  logic                          cfgRd,
  input  logic [ctlf_pkg::ROW_W-1:0]    cfgWrData,
  output logic [ctlf_pkg::ROW_W-1:0]    cfgRdData,
  output logic                          cfgRdValid,
  input  logic                          hdrDone,
  input  logic [ctlf_pkg::ADDR_BITS-1:0] hdrDa,
  input  logic [ctlf_pkg::ADDR_BITS-1:0] hdrSa,
  input  logic [ctlf_pkg::ET_BITS-1:0]  hdrEtype,
  output logic                          decValid,
  output logic                          decMatch,
  output logic                          decBypass,
  output logic [IDX_W-1:0]              decRow
);
  ctlStrobe_t       stb;
  logic [IDX_W-1:0] rowIdx;
  ctlfRow_t         rdRow;

  ctlf_ctrl #(
    .ROWS(ROWS), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .TABLE_SEL(TABLE_SEL)
  ) u_ctrl (
    .cfgAddr(cfgAddr),
    .cfgSel (cfgSel),
    .cfgWr  (cfgWr),
    .cfgRd  (cfgRd),
    .hdrDone(hdrDone),
    .stb    (stb),
    .rowIdx (rowIdx)
  );

  ctlf_datapath #(.ROWS(ROWS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rowIdx   (rowIdx),
    .wrRow    (ctlfRow_t'(cfgWrData)),
    .da       (hdrDa),
    .sa       (hdrSa),
    .et       (hdrEtype),
    .rdRow    (rdRow),
    .rdValid  (cfgRdValid),
    .decValid (decValid),
    .decMatch (decMatch),
    .decBypass(decBypass),
    .decRow   (decRow)
  );

  assign cfgRdData = rdRow;
endmodule

// File: rtl/ctlf_checker.sv
module ctlf_checker #(
  parameter int ROWS      = 24,
  parameter int ADDR_W    = 9,
  parameter int SEL_W     = 4,
  parameter int TABLE_SEL = 0,
  localparam int IDX_W    = $clog2(ROWS)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [ADDR_W-1:0]          cfgAddr,
  input logic [SEL_W-1:0]           cfgSel,
  input logic                       cfgRd,
  input logic [ctlf_pkg::ROW_W-1:0] cfgRdData,
  input logic                       cfgRdValid,
  input logic                       hdrDone,
  input logic                       decValid,
  input logic                       decMatch,
  input logic                       decBypass,
  input logic [IDX_W-1:0]           decRow
);
  logic badAccess;
  assign badAccess = (cfgSel != SEL_W'(TABLE_SEL)) || (cfgAddr >= ADDR_W'(ROWS));

  // R4: decision strobe follows the header strobe by one cycle
  a_r4_valid_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    hdrDone |=> decValid);
  a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !hdrDone |=> !decValid);

  // R2: read data returns one cycle after the read strobe
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    cfgRd |=> cfgRdValid);
  a_r2_no_spurious_read: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRd |=> !cfgRdValid);

  // R3: reads outside the table return zero
  a_r3_bad_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRd && badAccess) |=> (cfgRdData == '0));

  // R11: a miss leaves the rest of the decision clean
  a_r11_miss_clean: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decMatch) |-> (!decBypass && decRow == '0));

  // R12: bypass only together with a match
  a_r12_bypass_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    decBypass |-> decMatch);

  // R10: winning row stays inside the table
  a_r10_row_in_table: assert property (@(posedge clk) disable iff (!rstN)
    decMatch |-> (int'(decRow) < ROWS));
endmodule

bind ctlf_filter ctlf_checker #(
  .ROWS(ROWS), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .TABLE_SEL(TABLE_SEL)
) u_chk (.*);

// File: tb/test_ctlf_filter.sv
`timescale 1ns/1ps
module test_ctlf_filter;
  localparam int ROWS = 24;
  localparam int RW   = 84;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [8:0]    cfgAddr = '0;
  logic [3:0]    cfgSel = '0;
  logic          cfgWr = 1'b0;
  logic          cfgRd = 1'b0;
  logic [RW-1:0] cfgWrData = '0;
  logic [RW-1:0] cfgRdData;
  logic          cfgRdValid;
  logic          hdrDone = 1'b0;
  logic [47:0]   hdrDa = '0;
  logic [47:0]   hdrSa = '0;
  logic [15:0]   hdrEtype = '0;
  logic          decValid, decMatch, decBypass;
  logic [4:0]    decRow;

  int numChecks = 0;
  int numFails  = 0;
  bit finished  = 0;
  logic [RW-1:0] shadow [ROWS];
  logic [31:0]   lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  ctlf_filter i_ctlf_filter (.*);

  function automatic logic [RW-1:0] mkRow(logic [47:0] a, logic [15:0] e,
                                          logic [15:0] m, logic [2:0] t, logic act);
    return {a, e, m, t, act};
  endfunction

  // Arithmetic model of the rule table built from the requirements
  function automatic void model(input logic [47:0] da, input logic [47:0] sa,
                                input logic [15:0] et, output logic hit,
                                output logic byp, output logic [4:0] idx);
    hit = 0; byp = 0; idx = 0;
    for (int r = 0; r < ROWS; r++) begin
      logic [47:0] a = shadow[r][83:36];
      logic [15:0] e = shadow[r][35:20];
      logic [15:0] m = shadow[r][19:4];
      logic [2:0]  t = shadow[r][3:1];
      logic [47:0] fld;
      logic [15:0] tm;
      logic [63:0] fw, sw;
      logic ok;
      fld = 0; tm = 0;
      case (t)
        3'd1: begin fld = da; tm = 16'hFFF0; end
        3'd2: begin fld = sa; tm = 16'hFFF0; end
        3'd3: begin fld = {da[47:24], sa[23:0]}; tm = 16'hFFF0; end
        3'd4: begin fld = 0; tm = 16'h000F; end
        3'd5: begin fld = da; tm = 16'hFFFF; end
        3'd6: begin fld = sa; tm = 16'hFFFF; end
        default: ;
      endcase
      fw = {fld, et}; sw = {a, e};
      if (t == 3'd0) ok = 0;
      else if (t == 3'd7) ok = ({1'b0, da} >= {1'b0, a}) && ({1'b0, da} <= ({1'b0, a} + 49'(e)));
      else begin
        ok = 1;
        for (int n = 0; n < 16; n++)
          if (m[n] && tm[n] && (fw[4*n +: 4] != sw[4*n +: 4])) ok = 0;
      end
      if (ok && !hit) begin
        hit = 1; idx = 5'(r); byp = !shadow[r][0];
      end
    end
  endfunction

  task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeRow(input logic [3:0] sel, input logic [8:0] addr, input logic [RW-1:0] d);
    @(negedge clk);
    cfgSel = sel; cfgAddr = addr; cfgWrData = d; cfgWr = 1;
    @(negedge clk);
    cfgWr = 0;
    if (sel == 0 && addr < ROWS) shadow[addr] = d;
  endtask

  task automatic readRow(input string tag, input logic [3:0] sel, input logic [8:0] addr);
    logic [RW-1:0] exp;
    exp = (sel == 0 && addr < ROWS) ? shadow[addr] : '0;
    @(negedge clk);
    cfgSel = sel; cfgAddr = addr; cfgRd = 1;
    @(negedge clk);
    cfgRd = 0;
    check({tag, " rdValid"}, RW'(cfgRdValid), RW'(1));
    check({tag, " rdData"}, cfgRdData, exp);
  endtask

  task automatic frame(input string tag, input logic [47:0] da, input logic [47:0] sa,
                       input logic [15:0] et);
    logic h, b;
    logic [4:0] ix;
    model(da, sa, et, h, b, ix);
    @(negedge clk);
    hdrDa = da; hdrSa = sa; hdrEtype = et; hdrDone = 1;
    @(negedge clk);
    hdrDone = 0;
    check({tag, " decision"}, RW'({decValid, decMatch, decBypass, decRow}),
          RW'({1'b1, h, b, ix}));
    @(negedge clk);
    check("R4 valid drops", RW'(decValid), RW'(0));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      numChecks++; numFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ROWS; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 decValid", RW'(decValid), RW'(0));
    check("R1 rdValid", RW'(cfgRdValid), RW'(0));
    readRow("R1 row5", 4'd0, 9'd5);
    readRow("R1 row23", 4'd0, 9'd23);

    // R2 and R3: programming port
    writeRow(4'd0, 9'd3, mkRow(48'h777777_888888, 16'h0, 16'hFFFF, 3'd3, 1'b1));
    readRow("R2 row3", 4'd0, 9'd3);
    writeRow(4'd1, 9'd4, mkRow(48'hDEAD_BEEF_0001, 16'h1, 16'hFFFF, 3'd1, 1'b0));
    readRow("R3 wrong select ignored", 4'd0, 9'd4);
    readRow("R3 wrong select read", 4'd1, 9'd3);
    writeRow(4'd0, 9'd30, mkRow(48'hDEAD_BEEF_0002, 16'h1, 16'hFFFF, 3'd1, 1'b0));
    readRow("R3 out of range read", 4'd0, 9'd30);

    // Directed rule set
    writeRow(4'd0, 9'd0, mkRow(48'h0A0A_0A0A_0A0A, 16'h0, 16'hFFFF, 3'd0, 1'b0));
    writeRow(4'd0, 9'd1, mkRow(48'h1111_2222_3333, 16'h0, 16'hFFFF, 3'd1, 1'b1));
    writeRow(4'd0, 9'd2, mkRow(48'h4444_5555_6666, 16'h0, 16'hFFFF, 3'd2, 1'b0));
    writeRow(4'd0, 9'd4, mkRow(48'h0, 16'hABCD, 16'hFFFF, 3'd4, 1'b0));
    writeRow(4'd0, 9'd5, mkRow(48'h5555_AAAA_5555, 16'h1234, 16'hFFFF, 3'd5, 1'b1));
    writeRow(4'd0, 9'd6, mkRow(48'h6666_BBBB_6666, 16'h4321, 16'hFFFF, 3'd6, 1'b0));
    writeRow(4'd0, 9'd7, mkRow(48'h0000_1000_0000, 16'h0010, 16'hFFFF, 3'd7, 1'b1));
    writeRow(4'd0, 9'd9, mkRow(48'h9999_0000_0000, 16'h0, 16'hF000, 3'd1, 1'b1));
    writeRow(4'd0, 9'd15, mkRow(48'h9999_1234_5678, 16'h0, 16'hFFFF, 3'd1, 1'b0));

    frame("R5 unused row", 48'h0A0A_0A0A_0A0A, 48'h0, 16'h0);
    frame("R6 DA exact", 48'h1111_2222_3333, 48'h0, 16'h0);
    frame("R6 DA nibble miss", 48'h1111_2222_3334, 48'h0, 16'h0);
    writeRow(4'd0, 9'd1, mkRow(48'h1111_2222_3333, 16'h0, 16'hFFEF, 3'd1, 1'b1));
    frame("R6 masked nibble", 48'h1111_2222_3334, 48'h0, 16'h0);
    frame("R7 SA", 48'h0, 48'h4444_5555_6666, 16'h0);
    frame("R7 half DA half SA", 48'h777777_000000, 48'h000000_888888, 16'h0);
    frame("R7 half swapped miss", 48'h888888_000000, 48'h000000_777777, 16'h0);
    frame("R8 ethertype", 48'h0, 48'h0, 16'hABCD);
    frame("R8 DA plus ethertype", 48'h5555_AAAA_5555, 48'h0, 16'h1234);
    frame("R8 DA right ethertype wrong", 48'h5555_AAAA_5555, 48'h0, 16'h1235);
    frame("R8 SA plus ethertype", 48'h0, 48'h6666_BBBB_6666, 16'h4321);
    frame("R9 lower bound", 48'h0000_1000_0000, 48'h0, 16'h0);
    frame("R9 upper bound", 48'h0000_1000_0010, 48'h0, 16'h0);
    frame("R9 above", 48'h0000_1000_0011, 48'h0, 16'h0);
    frame("R9 below", 48'h0000_0FFF_FFFF, 48'h0, 16'h0);
    frame("R10 lowest row wins", 48'h9999_1234_5678, 48'h0, 16'h0);
    frame("R10 only row15 absent", 48'h9999_0000_0001, 48'h0, 16'h0);
    frame("R11 no match", 48'h3030_3030_3030, 48'h0, 16'h0101);
    frame("R12 bypass action0", 48'h0, 48'h4444_5555_6666, 16'h0);

    // R10 sweep: reprogram rows and classify near-miss frames
    for (int t = 0; t < 400; t++) begin
      int r;
      logic [47:0] da, sa;
      logic [15:0] et;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r = t % ROWS;
      if (lfsr[3:0] == 4'd0)
        writeRow(4'd0, 9'(r), mkRow({lfsr[15:0], lfsr[31:0]}, {8'h0, lfsr[11:4]},
                                   lfsr[27:12], lfsr[6:4], lfsr[7]));
      da = shadow[r][83:36]; sa = shadow[r][83:36]; et = shadow[r][35:20];
      if (lfsr[8]) da[4*lfsr[12:9] % 48 +: 4] = da[4*lfsr[12:9] % 48 +: 4] ^ 4'h5;
      if (lfsr[13]) sa[23:0] = ~sa[23:0];
      if (lfsr[14]) et = et + 16'(lfsr[16:15]);
      frame("R10 sweep", da, sa, et);
    end

    for (int i = 0; i < ROWS; i++) readRow("R2 final readback", 4'd0, 9'(i));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFails);
    $finish;
  end
endmodule